// File: doc/BRIEF.md
# Dithered PWM Slow DAC

This block drives four low-speed analog outputs, each from a single pulse pin followed by an external RC filter. Each channel is a PWM generator with a period of 256 clocks. Its duty cycle is set by a coarse value and is refined over a cycle of 16 periods. In each period, a 16-bit mask decides whether the high time grows by one extra clock. Averaged over the 16 periods, the output then has sixteen times more levels than the coarse value alone provides. This gives about 12 bits of effective resolution, while the comparator only counts to 256.

Software writes one 32-bit word per channel. The coarse value sits in bits 31:16 and the dither mask in bits 15:0. For a target code `n` between 0 and 2496, software writes `n/16` into the coarse field and sets `n mod 16` bits in the mask. Any placement of those bits gives the same average, so a spread pattern lowers ripple without moving the level.

All channels share one period counter and one dither-slot index. Each channel holds a shadow copy of its word. The shadow copy is reloaded only when a period ends, so a write never splits a period between old and new settings.

Top module: `dither_pwm_dac`

## Requirements
- R1: There are four channels. Each is set by its own 32-bit register, selected by the 2-bit word index `reg_idx` (index c equals byte offset 4*c). A write to one channel's register never changes another channel's register or output.
- R2: A read returns exactly the last 32-bit word written to the selected register, including coarse values above the clamp limit. `reg_rdata` is combinational from `reg_idx`.
- R3: After reset, every register reads zero and every pulse output is low.
- R4: Count clock edges after reset release from 1. Period p consists of the output values seen after edges 256p+1 through 256p+256. In that period, a channel is high for min(coarse, 156) + mask[p mod 16] clocks, where coarse is bits 31:16 and mask is bits 15:0 of the channel's word.
- R5: The dither slot starts at 0 in period 0 and advances by one per period. It wraps from 15 back to 0.
- R6: A register write takes effect at the first period boundary after it. The period in progress keeps its old high time, even when the write lands in the middle of that period.
- R7: Coarse values above 156 act as 156. A high time never exceeds 157 clocks in any period.
- R8: Over any 16 aligned periods with a constant word, the total high time equals 16*min(coarse,156) plus the number of ones in the mask. This holds whatever the placement of those ones.
- R9: Channels loaded with different words at the same time each follow their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Channel register select (word index) |
| reg_wdata | input | 32 | Write data: coarse in 31:16, mask in 15:0 |
| reg_rdata | output | 32 | Read data of the selected register |
| pwm_out | output | 4 | Pulse output, one bit per channel |

## Verification
Directed words cover several corner cases, each with its own purpose:
- A single mask bit shows which slot is live in each period.
- An all-ones mask at coarse 156 hits the 157-clock ceiling.
- An over-range coarse value must clamp, yet still read back unchanged.

A contiguous mask (0x00FF) and an alternating mask (0x5555) of equal weight run side by side. Their 16-period totals must match, which separates a correct sequencer from one that mis-indexes slots. A write placed mid-period separates boundary-loaded shadows from direct loading. Random words with random masks on all four channels at once expose any crosstalk between channels or errors in the clamp arithmetic.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int DW = 32;   // register word width
  localparam int MW = 16;   // dither mask width
  localparam int SW = 4;    // slot index width
  localparam int CW = 8;    // PWM counter width

  typedef logic [DW-1:0] word_t;

  // High time of one period for a word and slot, coarse clamped to cmax.
  function automatic logic [CW:0] dpd_high_time(word_t w, logic [SW-1:0] slot,
                                                int unsigned cmax);
    logic [MW-1:0] coarse;
    logic [CW:0]   base;
    coarse = w[DW-1:MW];
    if (32'(coarse) > cmax) base = cmax[CW:0];
    else                    base = coarse[CW:0];
    return base + {{CW{1'b0}}, w[slot]};
  endfunction
endpackage

// File: rtl/dpd_sequencer.sv
module dpd_sequencer
  import dpd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] slot,
  output logic          period_end
);
  assign period_end = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      slot <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (period_end) slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/dpd_regfile.sv
module dpd_regfile
  import dpd_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IW = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  word_t              wdata,
  output word_t              rdata,
  output logic [NUM_CH*DW-1:0] regs_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                         regs_flat[c*DW +: DW] <= '0;
      else if (we && idx == IW'(c))    regs_flat[c*DW +: DW] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (idx == IW'(c)) rdata = regs_flat[c*DW +: DW];
  end
endmodule

// File: rtl/dpd_channel.sv
module dpd_channel
  import dpd_pkg::*;
#(
  parameter int COARSE_MAX = 156
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  word_t         word_in,
  input  logic [SW-1:0] slot,
  input  logic [CW-1:0] cnt,
  output word_t         active,
  output logic          pwm
);
  logic [CW:0] high_time;
  assign high_time = dpd_high_time(active, slot, COARSE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      pwm    <= 1'b0;
    end else begin
      if (load) active <= word_in;
      pwm <= ({1'b0, cnt} < high_time);
    end
  end
endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac
  import dpd_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int COARSE_MAX = 156,
  localparam int IW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IW-1:0]     reg_idx,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [CW-1:0]        cnt;
  logic [SW-1:0]        slot;
  logic                 period_end;
  logic [NUM_CH*DW-1:0] regs_flat;
  logic [NUM_CH*DW-1:0] active_flat;

  dpd_sequencer u_seq (
    .clk(clk), .rst(rst), .cnt(cnt), .slot(slot), .period_end(period_end)
  );

  dpd_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .regs_flat(regs_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dpd_channel #(.COARSE_MAX(COARSE_MAX)) u_ch (
      .clk(clk), .rst(rst), .load(period_end),
      .word_in(regs_flat[c*DW +: DW]), .slot(slot), .cnt(cnt),
      .active(active_flat[c*DW +: DW]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker
  import dpd_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int COARSE_MAX = 156,
  localparam int IW = $clog2(NUM_CH)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 we,
  input logic [IW-1:0]        idx,
  input logic [DW-1:0]        wdata,
  input logic [CW-1:0]        cnt,
  input logic [SW-1:0]        slot,
  input logic                 period_end,
  input logic [NUM_CH*DW-1:0] regs_flat,
  input logic [NUM_CH*DW-1:0] active_flat,
  input logic [NUM_CH-1:0]    pwm_out
);
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    period_end |=> cnt == '0); // R4
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    period_end |=> slot == $past(slot) + 1'b1); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(slot)); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_WRITE_STORE: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IW'(c)) |=> regs_flat[c*DW +: DW] == $past(wdata)); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !period_end |=> $stable(active_flat[c*DW +: DW])); // R6
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
      period_end |=> active_flat[c*DW +: DW] == $past(regs_flat[c*DW +: DW])); // R6
    AST_HIGH_CAP: assert property (@(posedge clk) disable iff (rst)
      pwm_out[c] |-> 32'($past(cnt)) < COARSE_MAX + 1); // R7
  end
endmodule

bind dither_pwm_dac dpd_checker #(.NUM_CH(NUM_CH), .COARSE_MAX(COARSE_MAX)) u_chk (
  .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
  .cnt(cnt), .slot(slot), .period_end(period_end), .regs_flat(regs_flat),
  .active_flat(active_flat), .pwm_out(pwm_out)
);

// File: tb/dither_pwm_dac_test.sv
module dither_pwm_dac_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string cur_tag = "R3";

  logic [31:0] model_reg [NCH];
  logic [31:0] model_act [NCH];
  int acc [NCH];
  int sum16 [NCH];
  int last_sum [NCH];
  bit win_ok [NCH];

  dither_pwm_dac uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic int clamp_of(logic [31:0] w);
    int co;
    co = int'(w >> 16);
    return (co > 156) ? 156 : co;
  endfunction

  function automatic int exp_high(logic [31:0] w, int p);
    return clamp_of(w) + int'((w >> (p % 16)) & 32'd1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Period monitor: counts high clocks per channel and compares each period.
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      for (int c = 0; c < NCH; c++) acc[c] += int'(pwm_out[c]);
      if (cyc % 256 == 0) begin
        int p;
        p = cyc / 256 - 1;
        for (int c = 0; c < NCH; c++) begin
          int e;
          e = exp_high(model_act[c], p);
          chk(acc[c] == e, cur_tag, acc[c], e);          // R4 / R5 per period
          if (p % 16 == 0) begin sum16[c] = 0; win_ok[c] = 1'b1; end
          sum16[c] += acc[c];
          if (p % 16 == 15 && win_ok[c]) begin
            int e16;
            e16 = 16 * clamp_of(model_act[c]) + $countones(model_act[c][15:0]);
            chk(sum16[c] == e16, "R8", sum16[c], e16);
            last_sum[c] = sum16[c];
          end
          if (model_reg[c] != model_act[c]) win_ok[c] = 1'b0;
          model_act[c] = model_reg[c];                   // R6 boundary load
          acc[c] = 0;
        end
      end
    end
  end

  task automatic wr(int ch, logic [31:0] data);
    @(negedge clk);
    while ((cyc + 1) % 256 == 0) @(negedge clk);
    reg_we = 1'b1; reg_idx = 2'(ch); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    model_reg[ch] = data;
    #1;
    chk(reg_rdata == data, "R2", int'(reg_rdata), int'(data));
  endtask

  task automatic wait_periods(int n);
    repeat (n * 256) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < NCH; c++) begin
      model_reg[c] = '0; model_act[c] = '0; acc[c] = 0;
      sum16[c] = 0; last_sum[c] = 0; win_ok[c] = 1'b0;
    end
    repeat (5) @(negedge clk);
    // R3: reset state
    chk(pwm_out == 4'b0, "R3", int'(pwm_out), 0);
    for (int c = 0; c < NCH; c++) begin
      reg_idx = 2'(c);
      #1;
      chk(reg_rdata == 32'd0, "R3", int'(reg_rdata), 0);
    end
    rst = 1'b0;
    wait_periods(2);

    // R1 / R7: directed corner words on all channels
    cur_tag = "R7";
    wr(0, {16'd0, 16'h0001});
    wr(1, {16'd156, 16'hFFFF});
    wr(2, {16'd1000, 16'hAAAA});
    wr(3, {16'd156, 16'h0000});
    for (int c = 0; c < NCH; c++) begin
      reg_idx = 2'(c);
      #1;
      chk(reg_rdata == model_reg[c], "R1", int'(reg_rdata), int'(model_reg[c]));
    end
    cur_tag = "R5";
    wait_periods(34);

    // R6: mid-period write must not touch the period in progress
    cur_tag = "R6";
    while (cyc % 256 != 100) @(negedge clk);
    wr(0, {16'd40, 16'h0F0F});
    wr(1, {16'd3, 16'h0000});
    wait_periods(3);

    // R8: contiguous and spread masks of equal weight
    cur_tag = "R8";
    wr(0, {16'd10, 16'h00FF});
    wr(1, {16'd10, 16'h5555});
    wait_periods(34);
    chk(last_sum[0] == last_sum[1], "R8", last_sum[0], last_sum[1]);
    chk(last_sum[0] == 168, "R8", last_sum[0], 168);

    // R9: random words on all channels at once
    cur_tag = "R9";
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] w;
        w = {16'($urandom_range(0, 200)), 16'($urandom)};
        wr(c, w);
      end
      wait_periods(3);
    end

    wait_periods(1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule